// File: doc/BRIEF.md
# Interconnect Hang Monitor

This block sits next to a multi-master interconnect and detects transactions that never complete. Each master reports two kinds of single-cycle event. The first says a request was accepted, and carries the target slave index, the transaction ID and a write flag. The second says the master's oldest outstanding transaction has completed. For each master the block keeps a small in-order queue of outstanding transactions and times the one at the head. The timer runs against a programmable cycle limit.

When one or more heads reach the limit in the same cycle, the block picks the lowest-numbered master among them. It stores that master's index, slave, ID and direction, and sets a sticky raw interrupt bit. Software sees the event through a four-word register window. It can mask the interrupt output, clear the raw bit with a write pulse, and change the limit. The block takes no recovery action itself.

Top module: `xbar_hang_monitor`

## Requirements
- R1: Word 0 holds the 13-bit limit in bits [12:0]. It resets to 2048 and can be written. Bits above bit 12 are not stored and read back as 0.
- R2: A transaction accepted at clock edge E with no completion raises the raw bit at edge E+L, where L is the limit. A completion sampled at edge E+L or earlier prevents the event.
- R3: When several masters reach the limit at the same edge, the recorded master index is the lowest one among them.
- R4: Word 3 holds the record. The master index is in bits [3:0], the slave index in bits [10:8], the transaction ID in bits [19:16], and bit 24 is 1 for a write. All fields are 0 after reset.
- R5: The raw bit is cleared by writing 1 to bit 0 of word 2. This write acts only in the cycle it is made, and word 2 always reads 0.
- R6: Word 1 holds the enable in bit 0, which resets to 1 and can be written. Word 1 also shows the raw bit in bit 1 and the status in bit 2, where status is raw AND enable. The irq output equals the status.
- R7: While the raw bit is set, the record does not change. The record is loaded again by the first detection after a clear.
- R8: If a detection and a clear happen at the same edge, the raw bit stays set and the record takes the new event.
- R9: Each master holds up to 4 outstanding transactions. Completions retire them in acceptance order. When the head completes and another transaction is waiting, timing of the new head starts from 0 at that completion edge.
- R10: A head that has already timed out raises no further event until it completes.
- R11: A limit of 0 stops all detection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_vld | input | 16 | Request accepted, one bit per master |
| req_slv | input | 48 | Slave index per master, 3 bits each |
| req_id | input | 64 | Transaction ID per master, 4 bits each |
| req_wr | input | 16 | 1 when the accepted request is a write |
| rsp_vld | input | 16 | Oldest outstanding transaction completed, one bit per master |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr, combinational |
| irq | output | 1 | Masked hang interrupt |

## Verification
The raw bit and irq change at the edge that completes the L-th waiting cycle after acceptance or after the completion of the previous head. The checks sample them just after the edge where each event should land, and also just before it. Register writes act at the next edge, and reads return data in the same cycle. A behavioural model of per-master queues and ages is stepped at every rising edge, and irq and the selected read word are compared against it at every falling edge. Targeted checks against fixed values cover the exact detection edge, a completion that arrives in the last allowed cycle, simultaneous timeouts, a clear and a detection at the same edge, and masking.

// File: rtl/hm_pkg.sv
package hm_pkg;
    localparam int unsigned HM_ADDR_W = 2;
    localparam int unsigned HM_DATA_W = 32;

    localparam logic [HM_ADDR_W-1:0] HM_OFS_LIMIT  = 2'd0;
    localparam logic [HM_ADDR_W-1:0] HM_OFS_CTRL   = 2'd1;
    localparam logic [HM_ADDR_W-1:0] HM_OFS_CLEAR  = 2'd2;
    localparam logic [HM_ADDR_W-1:0] HM_OFS_RECORD = 2'd3;

    localparam int unsigned HM_CTRL_ENA  = 0;
    localparam int unsigned HM_CTRL_RAW  = 1;
    localparam int unsigned HM_CTRL_STAT = 2;

    localparam int unsigned HM_REC_MST = 0;
    localparam int unsigned HM_REC_SLV = 8;
    localparam int unsigned HM_REC_ID  = 16;
    localparam int unsigned HM_REC_WR  = 24;
endpackage

// File: rtl/hm_track.sv
// Per-master in-order queue of outstanding transactions; times the head only.
module hm_track #(
    parameter int SLV_W = 3,
    parameter int ID_W  = 4,
    parameter int TO_W  = 13,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TO_W-1:0]  limit,
    input  logic             req_vld,
    input  logic [SLV_W-1:0] req_slv,
    input  logic [ID_W-1:0]  req_id,
    input  logic             req_wr,
    input  logic             rsp_vld,
    output logic             expire,
    output logic [SLV_W-1:0] head_slv,
    output logic [ID_W-1:0]  head_id,
    output logic             head_wr
);
    localparam int EW = SLV_W + ID_W + 1;
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    typedef struct packed {
        logic [DEPTH-1:0][EW-1:0] slot;
        logic [PW-1:0]            rd;
        logic [PW-1:0]            wr;
        logic [CW-1:0]            used;
        logic [TO_W-1:0]          age;
        logic                     fired;
    } trk_t;

    trk_t st_d, st_q;
    logic pend, pop, push, ripe;

    function automatic logic [PW-1:0] step_ptr(input logic [PW-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d   = st_q;
        pend   = (st_q.used != '0);
        pop    = rsp_vld && pend;
        push   = req_vld && ((st_q.used != FULL) || pop);
        ripe   = (({1'b0, st_q.age} + 1'b1) >= {1'b0, limit});
        expire = pend && !st_q.fired && !pop && (limit != '0) && ripe;

        if (push) begin
            st_d.slot[st_q.wr] = {req_slv, req_id, req_wr};
            st_d.wr            = step_ptr(st_q.wr);
        end

        if (pop) begin
            st_d.rd    = step_ptr(st_q.rd);
            st_d.age   = '0;
            st_d.fired = 1'b0;
        end else if (pend && !st_q.fired) begin
            st_d.age   = st_q.age + 1'b1;
            st_d.fired = expire;
        end

        st_d.used = st_q.used + CW'(push) - CW'(pop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign {head_slv, head_id, head_wr} = st_q.slot[st_q.rd];
endmodule

// File: rtl/hm_pick.sv
// Lowest-index selection among the masters that timed out this cycle.
module hm_pick #(
    parameter int N  = 16,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  hit,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        any = |hit;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hit[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/hm_regs.sv
// Limit, enable, sticky raw bit, event record and read mux.
module hm_regs
    import hm_pkg::*;
#(
    parameter int TO_W      = 13,
    parameter int LIMIT_RST = 2048,
    parameter int MST_W     = 4,
    parameter int SLV_W     = 3,
    parameter int ID_W      = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic [HM_ADDR_W-1:0] reg_addr,
    input  logic [HM_DATA_W-1:0] reg_wdata,
    output logic [HM_DATA_W-1:0] reg_rdata,
    input  logic                 hit_any,
    input  logic [MST_W-1:0]     hit_mst,
    input  logic [SLV_W-1:0]     hit_slv,
    input  logic [ID_W-1:0]      hit_id,
    input  logic                 hit_wr,
    output logic [TO_W-1:0]      limit,
    output logic                 irq,
    output logic                 irq_raw,
    output logic [MST_W-1:0]     rec_mst,
    output logic [SLV_W-1:0]     rec_slv,
    output logic [ID_W-1:0]      rec_id,
    output logic                 rec_wr
);
    typedef struct packed {
        logic [TO_W-1:0]  limit;
        logic             ena;
        logic             raw;
        logic [MST_W-1:0] mst;
        logic [SLV_W-1:0] slv;
        logic [ID_W-1:0]  id;
        logic             wr;
    } cfg_t;

    function automatic cfg_t reset_val();
        cfg_t v = '0;
        v.limit = TO_W'(LIMIT_RST);
        v.ena   = 1'b1;
        return v;
    endfunction

    cfg_t st_d, st_q;
    logic wr_limit, wr_ctrl, clr;
    logic unused_wdata;

    assign unused_wdata = ^reg_wdata[HM_DATA_W-1:TO_W];

    always_comb begin
        st_d     = st_q;
        wr_limit = reg_wr && (reg_addr == HM_OFS_LIMIT);
        wr_ctrl  = reg_wr && (reg_addr == HM_OFS_CTRL);
        clr      = reg_wr && (reg_addr == HM_OFS_CLEAR) && reg_wdata[0];

        if (wr_limit) st_d.limit = reg_wdata[TO_W-1:0];
        if (wr_ctrl)  st_d.ena   = reg_wdata[HM_CTRL_ENA];

        if (hit_any && (!st_q.raw || clr)) begin
            st_d.mst = hit_mst;
            st_d.slv = hit_slv;
            st_d.id  = hit_id;
            st_d.wr  = hit_wr;
        end

        if (hit_any)  st_d.raw = 1'b1;
        else if (clr) st_d.raw = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= reset_val();
        else        st_q <= st_d;
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            HM_OFS_LIMIT: reg_rdata[TO_W-1:0] = st_q.limit;
            HM_OFS_CTRL: begin
                reg_rdata[HM_CTRL_ENA]  = st_q.ena;
                reg_rdata[HM_CTRL_RAW]  = st_q.raw;
                reg_rdata[HM_CTRL_STAT] = st_q.raw & st_q.ena;
            end
            HM_OFS_RECORD: begin
                reg_rdata[HM_REC_MST +: MST_W] = st_q.mst;
                reg_rdata[HM_REC_SLV +: SLV_W] = st_q.slv;
                reg_rdata[HM_REC_ID  +: ID_W]  = st_q.id;
                reg_rdata[HM_REC_WR]           = st_q.wr;
            end
            default: reg_rdata = '0;
        endcase
    end

    assign limit   = st_q.limit;
    assign irq_raw = st_q.raw;
    assign irq     = st_q.raw & st_q.ena;
    assign rec_mst = st_q.mst;
    assign rec_slv = st_q.slv;
    assign rec_id  = st_q.id;
    assign rec_wr  = st_q.wr;
endmodule

// File: rtl/xbar_hang_monitor.sv
module xbar_hang_monitor
    import hm_pkg::*;
#(
    parameter int N_MST     = 16,
    parameter int SLV_W     = 3,
    parameter int ID_W      = 4,
    parameter int TO_W      = 13,
    parameter int LIMIT_RST = 2048,
    parameter int OUT_DEPTH = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_MST-1:0]       req_vld,
    input  logic [N_MST*SLV_W-1:0] req_slv,
    input  logic [N_MST*ID_W-1:0]  req_id,
    input  logic [N_MST-1:0]       req_wr,
    input  logic [N_MST-1:0]       rsp_vld,
    input  logic                   reg_wr,
    input  logic [HM_ADDR_W-1:0]   reg_addr,
    input  logic [HM_DATA_W-1:0]   reg_wdata,
    output logic [HM_DATA_W-1:0]   reg_rdata,
    output logic                   irq
);
    localparam int MST_W = $clog2(N_MST);

    logic [TO_W-1:0]  limit;
    logic [N_MST-1:0] hit_vec;
    logic             hit_any;
    logic [MST_W-1:0] hit_idx;
    logic [SLV_W-1:0] head_slv [N_MST];
    logic [ID_W-1:0]  head_id  [N_MST];
    logic [N_MST-1:0] head_wr;
    logic             irq_raw;
    logic [MST_W-1:0] rec_mst;
    logic [SLV_W-1:0] rec_slv;
    logic [ID_W-1:0]  rec_id;
    logic             rec_wr;

    for (genvar g = 0; g < N_MST; g++) begin : g_trk
        hm_track #(
            .SLV_W(SLV_W), .ID_W(ID_W), .TO_W(TO_W), .DEPTH(OUT_DEPTH)
        ) u_trk (
            .clk      (clk),
            .rst_n    (rst_n),
            .limit    (limit),
            .req_vld  (req_vld[g]),
            .req_slv  (req_slv[g*SLV_W +: SLV_W]),
            .req_id   (req_id[g*ID_W +: ID_W]),
            .req_wr   (req_wr[g]),
            .rsp_vld  (rsp_vld[g]),
            .expire   (hit_vec[g]),
            .head_slv (head_slv[g]),
            .head_id  (head_id[g]),
            .head_wr  (head_wr[g])
        );
    end

    hm_pick #(.N(N_MST), .IW(MST_W)) u_pick (
        .hit (hit_vec),
        .any (hit_any),
        .idx (hit_idx)
    );

    hm_regs #(
        .TO_W(TO_W), .LIMIT_RST(LIMIT_RST), .MST_W(MST_W), .SLV_W(SLV_W), .ID_W(ID_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .hit_any   (hit_any),
        .hit_mst   (hit_idx),
        .hit_slv   (head_slv[hit_idx]),
        .hit_id    (head_id[hit_idx]),
        .hit_wr    (head_wr[hit_idx]),
        .limit     (limit),
        .irq       (irq),
        .irq_raw   (irq_raw),
        .rec_mst   (rec_mst),
        .rec_slv   (rec_slv),
        .rec_id    (rec_id),
        .rec_wr    (rec_wr)
    );
endmodule

// File: rtl/hm_checker.sv
module hm_checker
    import hm_pkg::*;
#(
    parameter int N_MST = 16,
    parameter int MST_W = 4,
    parameter int SLV_W = 3,
    parameter int ID_W  = 4,
    parameter int TO_W  = 13
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 reg_wr,
    input logic [HM_ADDR_W-1:0] reg_addr,
    input logic                 wdata0,
    input logic                 irq,
    input logic                 irq_raw,
    input logic [N_MST-1:0]     hit_vec,
    input logic                 hit_any,
    input logic [MST_W-1:0]     hit_idx,
    input logic [TO_W-1:0]      limit,
    input logic [MST_W-1:0]     rec_mst,
    input logic [SLV_W-1:0]     rec_slv,
    input logic [ID_W-1:0]      rec_id,
    input logic                 rec_wr
);
    logic [N_MST-1:0] below;
    logic             clr;

    assign below = (N_MST'(1) << hit_idx) - N_MST'(1);
    assign clr   = reg_wr && (reg_addr == HM_OFS_CLEAR) && wdata0;

    AST_MASK_BLOCKS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == HM_OFS_CTRL && !wdata0) |=> !irq); // R6

    AST_CLEAR_DROPS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !hit_any) |=> !irq_raw); // R5

    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        hit_any |=> irq_raw); // R8

    AST_RECORD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_raw && !(clr && hit_any)) |=> $stable({rec_mst, rec_slv, rec_id, rec_wr})); // R7

    AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        hit_any |-> (hit_vec[hit_idx] && ((hit_vec & below) == '0))); // R3

    AST_ZERO_LIMIT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (limit == '0) |-> !hit_any); // R11

    AST_RAW_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_raw) |-> $past(hit_any)); // R2
endmodule

bind xbar_hang_monitor hm_checker #(
    .N_MST(N_MST), .MST_W(MST_W), .SLV_W(SLV_W), .ID_W(ID_W), .TO_W(TO_W)
) u_hm_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .reg_wr  (reg_wr),
    .reg_addr(reg_addr),
    .wdata0  (reg_wdata[0]),
    .irq     (irq),
    .irq_raw (irq_raw),
    .hit_vec (hit_vec),
    .hit_any (hit_any),
    .hit_idx (hit_idx),
    .limit   (limit),
    .rec_mst (rec_mst),
    .rec_slv (rec_slv),
    .rec_id  (rec_id),
    .rec_wr  (rec_wr)
);

// File: tb/xbar_hang_monitor_tb_top.sv
module xbar_hang_monitor_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int N  = 16;
    localparam int SW = 3;
    localparam int IW = 4;
    localparam int DEPTH = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]    req_vld = '0;
    logic [N*SW-1:0] req_slv = '0;
    logic [N*IW-1:0] req_id = '0;
    logic [N-1:0]    req_wr = '0;
    logic [N-1:0]    rsp_vld = '0;
    logic          reg_wr = 1'b0;
    logic [1:0]    reg_addr = 2'd0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          irq;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xbar_hang_monitor dut_i (
        .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_slv(req_slv),
        .req_id(req_id), .req_wr(req_wr), .rsp_vld(rsp_vld), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    // Behavioural reference model
    int unsigned mq [N][$];
    int          age [N];
    bit          fired [N];
    logic [31:0] m_limit, m_ena, m_raw, m_mst, m_slv, m_id, m_wr;

    always @(posedge clk) begin
        int  f_idx;
        bit  clr, pend, pop, push, f;
        int unsigned e;
        if (!rst_n) begin
            for (int m = 0; m < N; m++) begin
                mq[m].delete(); age[m] = 0; fired[m] = 0;
            end
            m_limit = 2048; m_ena = 1; m_raw = 0;
            m_mst = 0; m_slv = 0; m_id = 0; m_wr = 0;
        end else begin
            f_idx = -1;
            for (int m = 0; m < N; m++) begin
                pend = mq[m].size() > 0;
                pop  = rsp_vld[m] && pend;
                f = pend && !fired[m] && !pop && (m_limit != 0) && (age[m] + 1 >= int'(m_limit));
                if (f && f_idx < 0) f_idx = m;
            end
            clr = reg_wr && reg_addr == 2'd2 && reg_wdata[0];
            if (f_idx >= 0 && (m_raw == 0 || clr)) begin
                e = mq[f_idx][0];
                m_mst = f_idx; m_slv = (e >> 5) & 7; m_id = (e >> 1) & 15; m_wr = e & 1;
            end
            if (f_idx >= 0) m_raw = 1;
            else if (clr)   m_raw = 0;
            if (reg_wr && reg_addr == 2'd0) m_limit = reg_wdata & 32'h1FFF;
            if (reg_wr && reg_addr == 2'd1) m_ena = reg_wdata & 1;
            for (int m = 0; m < N; m++) begin
                pend = mq[m].size() > 0;
                pop  = rsp_vld[m] && pend;
                push = req_vld[m] && (mq[m].size() < DEPTH || pop);
                f = pend && !fired[m] && !pop && (m_limit != 0) && (age[m] + 1 >= int'(m_limit));
                if (pop) void'(mq[m].pop_front());
                if (push) mq[m].push_back(req_slv[m*SW +: SW] * 32 + req_id[m*IW +: IW] * 2 + req_wr[m]);
                if (pop) begin
                    age[m] = 0; fired[m] = 0;
                end else if (pend && !fired[m]) begin
                    age[m] = (age[m] + 1) & 32'h1FFF;
                    if (f) fired[m] = 1;
                end
            end
        end
    end

    function automatic logic [31:0] exp_rdata(input logic [1:0] a);
        case (a)
            2'd0: return m_limit;
            2'd1: return {29'b0, m_raw[0] & m_ena[0], m_raw[0], m_ena[0]};
            2'd2: return 32'd0;
            default: return m_mst | (m_slv << 8) | (m_id << 16) | (m_wr << 24);
        endcase
    endfunction

    function automatic logic [31:0] rec(input int m, input int s, input int i, input int w);
        return 32'(m) | (32'(s) << 8) | (32'(i) << 16) | (32'(w) << 24);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Every-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R6 irq vs model", {31'b0, irq}, m_raw & m_ena);
            case (reg_addr)
                2'd0:    chk("R1 limit word vs model", reg_rdata, exp_rdata(reg_addr));
                2'd1:    chk("R6 control word vs model", reg_rdata, exp_rdata(reg_addr));
                2'd2:    chk("R5 clear word vs model", reg_rdata, exp_rdata(reg_addr));
                default: chk("R4 record word vs model", reg_rdata, exp_rdata(reg_addr));
            endcase
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
        req_vld = '0; rsp_vld = '0; reg_wr = 1'b0;
    endtask

    task automatic wreg(input logic [1:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
    endtask

    task automatic rchk(input string tag, input logic [1:0] a, input logic [31:0] exp);
        reg_addr = a;
        #1;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic issue(input int m, input int s, input int i, input int w);
        req_vld[m] = 1'b1;
        req_slv[m*SW +: SW] = SW'(s);
        req_id[m*IW +: IW]  = IW'(i);
        req_wr[m] = w[0];
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // reset state
        chk("R6 irq after reset", {31'b0, irq}, 0);
        rchk("R1 limit reset", 2'd0, 32'd2048);
        rchk("R6 enable reset", 2'd1, 32'd1);
        rchk("R4 record reset", 2'd3, 32'd0);

        // R1: program limit 6, upper bits dropped
        wreg(2'd0, 32'hFFFF_E006);
        rchk("R1 limit write", 2'd0, 32'd6);

        // R2: exact detection edge, R4 record layout
        issue(3, 5, 9, 1);
        tick();
        repeat (5) tick();
        chk("R2 no event before limit", {31'b0, irq}, 0);
        tick();
        chk("R2 event at limit", {31'b0, irq}, 1);
        rchk("R4 record fields", 2'd3, rec(3, 5, 9, 1));
        rchk("R6 control raw and status", 2'd1, 32'd7);

        // R5 clear, R10 no re-trigger of stuck head
        wreg(2'd2, 32'd1);
        chk("R5 clear drops irq", {31'b0, irq}, 0);
        rchk("R5 clear word reads zero", 2'd2, 32'd0);
        repeat (20) tick();
        chk("R10 stuck head stays silent", {31'b0, irq}, 0);
        rsp_vld[3] = 1'b1;
        tick();

        // R2 boundary: completion sampled at the limit edge
        issue(2, 1, 4, 0);
        tick();
        repeat (5) tick();
        rsp_vld[2] = 1'b1;
        tick();
        chk("R2 completion in last cycle", {31'b0, irq}, 0);
        repeat (10) tick();
        chk("R2 still no event", {31'b0, irq}, 0);

        // R3 simultaneous timeouts, second queued on master 4
        issue(9, 2, 3, 0);
        issue(4, 6, 10, 1);
        issue(12, 7, 15, 1);
        tick();
        issue(4, 3, 12, 0);
        tick();
        repeat (4) tick();
        chk("R3 none before limit", {31'b0, irq}, 0);
        tick();
        chk("R3 event raised", {31'b0, irq}, 1);
        rchk("R3 lowest master recorded", 2'd3, rec(4, 6, 10, 1));

        // R7 record frozen while raw set
        issue(7, 1, 1, 1);
        tick();
        repeat (6) tick();
        rchk("R7 record frozen", 2'd3, rec(4, 6, 10, 1));
        wreg(2'd2, 32'd1);
        chk("R5 clear again", {31'b0, irq}, 0);

        // R9 next head timed from completion edge
        rsp_vld[4] = 1'b1;
        tick();
        repeat (5) tick();
        chk("R9 new head not yet expired", {31'b0, irq}, 0);
        tick();
        chk("R9 new head expired", {31'b0, irq}, 1);
        rchk("R9 R7 record reloaded after clear", 2'd3, rec(4, 3, 12, 0));

        // R8 detection and clear at the same edge
        wreg(2'd2, 32'd1);
        issue(0, 4, 7, 1);
        tick();
        repeat (5) tick();
        wreg(2'd2, 32'd1);
        chk("R8 set wins over clear", {31'b0, irq}, 1);
        rchk("R8 record takes new event", 2'd3, rec(0, 4, 7, 1));

        // R6 masking
        wreg(2'd1, 32'd0);
        chk("R6 masked irq", {31'b0, irq}, 0);
        rchk("R6 raw visible while masked", 2'd1, 32'd2);
        wreg(2'd1, 32'd1);
        chk("R6 unmasked irq", {31'b0, irq}, 1);

        // R11 zero limit disables detection
        wreg(2'd2, 32'd1);
        wreg(2'd0, 32'd0);
        issue(5, 2, 2, 0);
        tick();
        repeat (40) tick();
        chk("R11 zero limit silent", {31'b0, irq}, 0);
        rchk("R11 raw stays clear", 2'd1, 32'd1);

        repeat (2) tick();
        finish_run();
    end
endmodule